// File: doc/BRIEF.md
# Serial video line capture front-end

This block is the receiving end of a one-bit-per-pixel monochrome video link, sitting on the panel side ahead of a frame store. It samples pixel data, a pixel strobe, horizontal sync and vertical sync in the system clock domain. It locates the top line of each frame, counts pixels along each line and packs the visible ones into 8-pixel words. Each word leaves through a single-cycle write strobe with a word address into a 640 by 400 store. The refresh scanner that reads the store, and the store itself, lie outside the block.

Two static options widen the link. In pair mode every strobe carries two neighbouring pixels, the left one of each pair on a second data pin. This halves the strobe rate. In double mode each incoming line fills two stacked rows, so 200 input lines cover the whole 400-row store.

A four-state controller tracks the frame:

- `CAP_WAIT` is the state after reset. It leaves only on a frame start.
- `CAP_LINE` takes pixels. On a line start it stays in `CAP_LINE` if the next row exists, and otherwise moves to `CAP_DONE`. It moves to `CAP_FULL` once the 640th pixel of the line has been taken.
- `CAP_FULL` drops pixels. On a line start it goes to `CAP_LINE` or `CAP_DONE`, by the same row test as `CAP_LINE`.
- `CAP_DONE` drops everything until the next frame start.

A frame start sends any state to `CAP_LINE`.

Top module: `vrx_line_capture`

## Requirements
- R1: A frame start is a rising edge of `vsync`, sampled while `hsync` is high. It sets the row to 0 and the column to 0, and drops any partly packed word. Pixels that follow it are written from word address 0.
- R2: A rising edge of `hsync` that is not a frame start begins a new line. It resets the column to 0, drops any partly packed word, and advances the row by one (by two in double mode). A line that ends with fewer than 8 pending pixels writes nothing for them.
- R3: Only the first 640 pixels taken after a line or frame start are written. Every later pixel on that line produces no write.
- R4: Pixels are packed 8 per word, with the leftmost pixel in bit 7. The word address is row*80 + column/8. `wr_en` is high for exactly the cycle after the clock edge that samples the word's eighth pixel.
- R5: With `pair_mode` high, each strobe takes two pixels. `vid_odd` carries the left pixel of the pair (columns 1, 3, 5… counting from 1 at the viewer's left) and occupies the higher bit. `vid_main` carries the right pixel (columns 2, 4, 6…).
- R6: With `double_mode` high, each completed word is written to row r in the cycle after completion. It is written again to row r+1 (address + 80), with the same data, in the following cycle.
- R7: Lines beyond the last row are ignored until the next frame start: beyond 400 input lines normally, or beyond 200 in double mode. Writing resumes from row 0 after that frame start.
- R8: After reset `wr_en` is low, and no write occurs until the first frame start. A sync held high through reset produces no edge.
- R9: A pixel strobe in the same cycle as a line start is taken as column 0 of the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe; data pins are taken when high |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| vid_main | input | 1 | Pixel data; the right pixel of a pair in pair mode |
| vid_odd | input | 1 | Left pixel of each pair in pair mode, unused otherwise |
| pair_mode | input | 1 | Two pixels per strobe |
| double_mode | input | 1 | Each input line written to two rows |
| wr_en | output | 1 | Frame store write strobe |
| wr_addr | output | AW (15) | Word address, row*80 + word |
| wr_data | output | 8 | Packed pixels, leftmost in bit 7 |

## Verification
A full-width line is followed by a line that overruns 640 pixels. This separates correct truncation from counters that wrap or keep writing. A 12-pixel line shows whether a partial word is discarded or leaks into the next row. A line whose first strobe coincides with the sync edge shows whether that pixel lands in column 0 or is lost. A 402-line frame of short lines, and a 202-line frame in double mode, test the row ceiling and the echoed second write. A pair-mode frame catches swapped odd and even pins. Every write, with its cycle, address and data, is compared with a behavioural model on every clock.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
    typedef enum logic [1:0] {
        CAP_WAIT = 2'd0,
        CAP_LINE = 2'd1,
        CAP_FULL = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_t;
endpackage

// File: rtl/vrx_sync_edge.sv
module vrx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    output logic line_start,
    output logic frame_start
);
    logic hs_q;
    logic vs_q;

    // previous samples reset high so a level held through reset is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1;
            vs_q <= 1'b1;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
        end
    end

    assign frame_start = vsync & ~vs_q & hsync;
    assign line_start  = hsync & ~hs_q;
endmodule

// File: rtl/vrx_pixel_packer.sv
module vrx_pixel_packer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              pair,
    input  logic              bit_main,
    input  logic              bit_odd,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] base;

    always_comb begin
        base      = clear ? '0 : shift_q;
        word_next = base;
        if (take) begin
            if (pair) begin
                word_next = {base[WORD_W-3:0], bit_odd, bit_main};
            end else begin
                word_next = {base[WORD_W-2:0], bit_main};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= word_next;
        end
    end
endmodule

// File: rtl/vrx_write_issuer.sv
module vrx_write_issuer #(
    parameter int AW     = 15,
    parameter int WORD_W = 8,
    parameter int WPR    = 80,
    parameter int DEPTH  = 32000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [AW-1:0]     word_addr,
    input  logic [WORD_W-1:0] word_data,
    input  logic              dbl,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    localparam logic [AW-1:0] ROW_STEP = AW'(WPR);

    logic echo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            echo_q  <= 1'b0;
        end else if (word_done) begin
            wr_en   <= 1'b1;
            wr_addr <= word_addr;
            wr_data <= word_data;
            echo_q  <= dbl;
        end else if (echo_q) begin
            wr_en   <= 1'b1;
            wr_addr <= wr_addr + ROW_STEP;
            echo_q  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
        end
    end

    AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        echo_q |-> !word_done); // R6
    AST_ECHO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && dbl) |=> ##1 (wr_en && $stable(wr_data) && wr_addr == $past(wr_addr) + ROW_STEP)); // R6
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < DEPTH)); // R7
endmodule

// File: rtl/vrx_line_capture.sv
module vrx_line_capture
    import vrx_pkg::*;
#(
    parameter int H_PIX  = 640,
    parameter int V_ROWS = 400,
    parameter int WORD_W = 8,
    localparam int WPR   = H_PIX / WORD_W,
    localparam int DEPTH = V_ROWS * WPR,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              vid_main,
    input  logic              vid_odd,
    input  logic              pair_mode,
    input  logic              double_mode,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    localparam int CW = $clog2(H_PIX + 1);
    localparam int RW = $clog2(V_ROWS + 2);
    localparam int WB = $clog2(WORD_W);
    localparam logic [AW-1:0] STEP1 = AW'(WPR);
    localparam logic [AW-1:0] STEP2 = AW'(2 * WPR);

    logic              line_start;
    logic              frame_start;
    cap_state_t        state_q, state_d, st_eff;
    logic [CW-1:0]     col_q, col_eff, col_new, col_step;
    logic [RW-1:0]     row_q, row_eff, row_try;
    logic [AW-1:0]     base_q, base_eff;
    logic              clear;
    logic              take;
    logic              word_done;
    logic [AW-1:0]     word_addr;
    logic [WORD_W-1:0] word_data;

    vrx_sync_edge u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync       (hsync),
        .vsync       (vsync),
        .line_start  (line_start),
        .frame_start (frame_start)
    );

    vrx_pixel_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .take      (take),
        .pair      (pair_mode),
        .bit_main  (vid_main),
        .bit_odd   (vid_odd),
        .word_next (word_data)
    );

    vrx_write_issuer #(.AW(AW), .WORD_W(WORD_W), .WPR(WPR), .DEPTH(DEPTH)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_addr (word_addr),
        .word_data (word_data),
        .dbl       (double_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign col_step = pair_mode ? CW'(2) : CW'(1);
    assign row_try  = row_q + (double_mode ? RW'(2) : RW'(1));

    // sync events settle the line context first; a strobe in the same cycle
    // then lands in that new context
    always_comb begin
        st_eff   = state_q;
        col_eff  = col_q;
        row_eff  = row_q;
        base_eff = base_q;
        clear    = 1'b0;
        if (frame_start) begin
            st_eff   = CAP_LINE;
            col_eff  = '0;
            row_eff  = '0;
            base_eff = '0;
            clear    = 1'b1;
        end else if (line_start) begin
            clear   = 1'b1;
            col_eff = '0;
            unique case (state_q)
                CAP_WAIT: st_eff = CAP_WAIT;
                CAP_DONE: st_eff = CAP_DONE;
                CAP_LINE, CAP_FULL: begin
                    if (32'(row_try) < V_ROWS) begin
                        st_eff   = CAP_LINE;
                        row_eff  = row_try;
                        base_eff = base_q + (double_mode ? STEP2 : STEP1);
                    end else begin
                        st_eff = CAP_DONE;
                    end
                end
            endcase
        end

        take      = pix_valid && (st_eff == CAP_LINE);
        col_new   = take ? col_eff + col_step : col_eff;
        word_done = take && (col_new[WB-1:0] == '0);
        word_addr = base_eff + AW'(col_new >> WB) - AW'(1);
        state_d   = (take && 32'(col_new) >= H_PIX) ? CAP_FULL : st_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            base_q <= '0;
        end else begin
            col_q  <= col_new;
            row_q  <= row_eff;
            base_q <= base_eff;
        end
    end

    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(col_q) <= H_PIX); // R3
    AST_FULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_FULL && !line_start && !frame_start) |-> !word_done); // R3
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_WAIT && !frame_start) |-> !word_done); // R8
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_DONE && !frame_start) |-> !word_done); // R7
    AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_LINE || state_q == CAP_FULL) |-> (32'(row_q) < V_ROWS)); // R7
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q != CAP_WAIT && state_q != CAP_DONE)); // R1
endmodule

// File: tb/vrx_line_capture_test.sv
module vrx_line_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        vid_main = 1'b0;
    logic        vid_odd = 1'b0;
    logic        pair_mode = 1'b0;
    logic        double_mode = 1'b0;
    logic        wr_en;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_count = 0;
    int mem[int];
    int exp_a[int];
    int exp_d[int];

    // model state
    bit m_started, m_ended, m_hp, m_vp, m_fs, m_hr;
    int m_row, m_col, m_acc;

    vrx_line_capture uut (
        .clk (clk), .rst_n (rst_n), .pix_valid (pix_valid),
        .hsync (hsync), .vsync (vsync), .vid_main (vid_main), .vid_odd (vid_odd),
        .pair_mode (pair_mode), .double_mode (double_mode),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    always #5 clk = ~clk;

    function automatic bit pix(int ln, int c);
        return (((ln * 5 + c * 3 + c / 8) % 7) < 3);
    endfunction

    function automatic int exp_word(int ln, int w);
        int v = 0;
        for (int i = 0; i < 8; i++) v = (v << 1) | int'(pix(ln, w * 8 + i));
        return v;
    endfunction

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // behavioural reference, evaluated on the sampled inputs of each edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_started = 0; m_ended = 0; m_hp = 1; m_vp = 1;
            m_row = 0; m_col = 0; m_acc = 0;
        end else begin
            m_fs = vsync && !m_vp && hsync;
            m_hr = hsync && !m_hp;
            if (m_fs) begin
                m_started = 1; m_ended = 0; m_row = 0; m_col = 0; m_acc = 0;
            end else if (m_hr) begin
                m_col = 0; m_acc = 0;
                if (m_started && !m_ended) begin
                    m_row += double_mode ? 2 : 1;
                    if (m_row >= 400) m_ended = 1;
                end
            end
            if (pix_valid && m_started && !m_ended && m_col < 640) begin
                if (pair_mode) begin
                    m_acc = (m_acc << 2) | (int'(vid_odd) << 1) | int'(vid_main);
                    m_col += 2;
                end else begin
                    m_acc = (m_acc << 1) | int'(vid_main);
                    m_col += 1;
                end
                if (m_col % 8 == 0) begin
                    exp_a[cyc] = m_row * 80 + m_col / 8 - 1;
                    exp_d[cyc] = m_acc & 255;
                    if (double_mode) begin
                        exp_a[cyc + 1] = m_row * 80 + m_col / 8 - 1 + 80;
                        exp_d[cyc + 1] = m_acc & 255;
                    end
                    m_acc = 0;
                end
            end
            m_hp = hsync;
            m_vp = vsync;
        end
    end

    // cycle-by-cycle comparison of the write port (R4, R6 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (exp_a.exists(cyc)) begin
                if (!wr_en || int'(wr_addr) != exp_a[cyc] || int'(wr_data) != exp_d[cyc]) begin
                    failures++;
                    $display("FAIL R4/R6 write stream cyc=%0d actual en=%0d addr=%0d data=%0d expected en=1 addr=%0d data=%0d",
                             cyc, wr_en, wr_addr, wr_data, exp_a[cyc], exp_d[cyc]);
                end
                exp_a.delete(cyc);
                exp_d.delete(cyc);
            end else if (wr_en) begin
                failures++;
                $display("FAIL R4/R8 write stream cyc=%0d actual en=1 addr=%0d expected en=0", cyc, wr_addr);
            end
            if (wr_en) begin
                mem[int'(wr_addr)] = int'(wr_data);
                wr_count++;
            end
        end
    end

    task automatic drive_px(int ln, int k, bit pr);
        if (pr) begin
            vid_odd  = pix(ln, k);
            vid_main = pix(ln, k + 1);
        end else begin
            vid_main = pix(ln, k);
            vid_odd  = 1'b0;
        end
        pix_valid = 1'b1;
    endtask

    task automatic run_line(int ln, bit fs, int npix, bit px_on_hs);
        int k = 0;
        int step = pair_mode ? 2 : 1;
        @(negedge clk);
        hsync = 1'b1;
        if (px_on_hs) begin
            drive_px(ln, k, pair_mode);
            k += step;
        end
        @(negedge clk);
        pix_valid = 1'b0;
        if (fs) vsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        while (k < npix) begin
            drive_px(ln, k, pair_mode);
            k += step;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int wc0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R8 reset wr_en", int'(wr_en), 0);

        // lines before any frame start
        run_line(5, 0, 16, 0);
        run_line(6, 0, 16, 0);
        settle();
        chk("R8 no writes before frame", wr_count, 0);

        // single mode frame
        mem.delete();
        wc0 = wr_count;
        run_line(0, 1, 640, 0);
        run_line(1, 0, 700, 0);
        run_line(2, 0, 12, 0);
        run_line(3, 0, 16, 1);
        settle();
        chk("R1 row0 word0", mem[0], exp_word(0, 0));
        chk("R1 row0 word79", mem[79], exp_word(0, 79));
        chk("R4 row1 word5", mem[85], exp_word(1, 5));
        chk("R3 row1 last word", mem[159], exp_word(1, 79));
        chk("R3 write count frame", wr_count - wc0, 163);
        chk("R2 row2 word0", mem[160], exp_word(2, 0));
        chk("R2 partial dropped", int'(mem.exists(161)), 0);
        chk("R9 hs-cycle pixel word0", mem[240], exp_word(3, 0));
        chk("R9 hs-cycle pixel word1", mem[241], exp_word(3, 1));

        // row ceiling
        mem.delete();
        wc0 = wr_count;
        for (int i = 0; i < 402; i++) run_line(i, i == 0, 8, 0);
        settle();
        chk("R7 writes capped at 400 rows", wr_count - wc0, 400);
        chk("R7 last row", mem[399 * 80], exp_word(399, 0));
        run_line(50, 1, 8, 0);
        settle();
        chk("R7 resumes after frame start", mem[0], exp_word(50, 0));
        chk("R7 resume count", wr_count - wc0, 401);

        // pair mode
        pair_mode = 1'b1;
        mem.delete();
        wc0 = wr_count;
        run_line(0, 1, 640, 0);
        run_line(1, 0, 640, 0);
        settle();
        chk("R5 pair row0 word0", mem[0], exp_word(0, 0));
        chk("R5 pair row1 word33", mem[80 + 33], exp_word(1, 33));
        chk("R5 pair write count", wr_count - wc0, 160);

        // double mode
        pair_mode = 1'b0;
        double_mode = 1'b1;
        mem.delete();
        wc0 = wr_count;
        for (int i = 0; i < 202; i++) run_line(i, i == 0, 16, 0);
        settle();
        chk("R6 row0", mem[0], exp_word(0, 0));
        chk("R6 row1 copy", mem[80], exp_word(0, 0));
        chk("R6 input1 to row2", mem[161], exp_word(1, 1));
        chk("R6 bottom row", mem[399 * 80 + 1], exp_word(199, 1));
        chk("R7 double write count", wr_count - wc0, 800);

        settle();
        chk("R4 no pending writes", exp_a.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule